// File: doc/BRIEF.md
# Machine Cycle Timing Sequencer

This block paces a microcoded 8-bit processor core. From one clock it produces two one-hot state vectors: the machine cycle (M1 to M6) and the clock period within that machine cycle (T1 to T6). Left alone, it steps through the clock periods of each machine cycle and then moves on to the next machine cycle. The execution engine steers it with two controls. A restart input ends the current instruction and returns the sequence to M1/T1. A next-cycle input begins a new functional sub-operation: it moves to the following machine cycle and restarts the clock periods at T1.

During interrupt service a small hold state machine stretches M1/T2 by two clocks, so that the request has time to propagate. It has three states. `PH_RUN` is normal stepping. `PH_HOLD1` is the first inserted clock. `PH_HOLD2` is the second inserted clock. The transitions are:

- `PH_RUN -> PH_HOLD1` when the service flag is high at M1/T2 and no control is asserted.
- `PH_HOLD1 -> PH_HOLD2` when no control is asserted.
- `PH_HOLD1 -> PH_RUN` when a control is asserted.
- `PH_HOLD2 -> PH_RUN` always. On this transition the period advances to T3.

In the M1/T3 state the block raises a load strobe for the instruction register. The first two clocks of M1 are left for the previous instruction to retire.

Top module: `mcycle_sequencer`

## Requirements
- R1: A synchronous active-high `rst` puts the outputs at M1/T1 (`mcyc_o`=6'b000001, `tclk_o`=6'b000001) on the next clock. It also returns the hold machine to `PH_RUN`, which holds both hold outputs low, including when reset arrives in the middle of a hold.
- R2: With no control inputs, `tclk_o` steps from bit 0 (T1) one bit per clock up to bit 5 (T6), and then returns to T1.
- R3: The clock that leaves T6 also moves `mcyc_o` up one bit. `mcyc_o` saturates at bit 5 (M6): after M6/T6 the state is M6/T1.
- R4: If `set_first_i` is high at a clock edge, the state after that edge is M1/T1.
- R5: If `next_cycle_i` is high at a clock edge (and `set_first_i` is low), the machine cycle moves up one bit, saturating at M6, and the period returns to T1.
- R6: When `set_first_i` and `next_cycle_i` are both high, `set_first_i` wins and the state becomes M1/T1.
- R7: Suppose `irq_service_i` is high at M1/T2 with no control asserted. The next clock then shows `hold_first_o`=1 and the clock after shows `hold_second_o`=1. `tclk_o` stays at T2 through both of these clocks, and on the following clock the state is M1/T3.
- R8: No hold is inserted if `irq_service_i` is low at M1/T2, or at any state other than M1/T2. Each entry into M1/T2 inserts at most one pair of hold clocks.
- R9: `ir_load_o` is high exactly while the state is M1/T3. It is never high in any other state or during a hold clock.
- R10: `mcyc_o` and `tclk_o` each have exactly one bit set. `hold_first_o` and `hold_second_o` are never high together.
- R11: A control input asserted during a hold clock takes effect at once, as in R4 to R6, and ends the hold. Both hold outputs are low after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| set_first_i | input | 1 | Instruction complete: restart at M1/T1 |
| next_cycle_i | input | 1 | Begin next machine cycle at T1 |
| irq_service_i | input | 1 | Interrupt service in progress |
| mcyc_o | output | 6 | One-hot machine cycle, bit 0 = M1 |
| tclk_o | output | 6 | One-hot clock period, bit 0 = T1 |
| hold_first_o | output | 1 | First inserted hold clock |
| hold_second_o | output | 1 | Second inserted hold clock |
| ir_load_o | output | 1 | Instruction register load strobe (M1/T3) |

## Verification
On every cycle the assertions check the following:
- both state vectors stay one-hot;
- M6 saturates;
- restart and next-cycle give the correct state after the edge;
- a first hold clock is always followed by a second one, unless it is cancelled;
- the period stays frozen across both hold clocks;
- the load strobe appears only directly after T2.

Only the directed scenarios show the rest. These are the full stepping order through every M/T pair, and the exact clock on which the holds begin. They also cover the absence of holds when the service flag is low or the state is M2/T2, reset and cancellation arriving in the middle of a hold, and the priority between the two controls.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [1:0] {
        PH_RUN   = 2'd0,
        PH_HOLD1 = 2'd1,
        PH_HOLD2 = 2'd2
    } hold_phase_e;

endpackage

// File: rtl/seq_onehot_counter.sv
module seq_onehot_counter #(
    parameter int WIDTH    = 6,
    parameter bit SATURATE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    output logic [WIDTH-1:0] state
);

    localparam logic [WIDTH-1:0] FIRST = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] stepped;

    generate
        if (SATURATE) begin : g_sat
            always_comb begin
                if (state_q[WIDTH-1]) begin
                    stepped = state_q;
                end else begin
                    stepped = state_q << 1;
                end
            end
        end else begin : g_wrap
            always_comb begin
                stepped = {state_q[WIDTH-2:0], state_q[WIDTH-1]};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (clear) begin
            state_q <= FIRST;
        end else if (advance) begin
            state_q <= stepped;
        end
    end

    assign state = state_q;

    // R10
    onehot_state_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(state_q) == 1);

    generate
        if (SATURATE) begin : g_sat_chk
            // R3
            top_saturates_chk: assert property (@(posedge clk) disable iff (rst)
                (state_q[WIDTH-1] && !clear) |=> state_q[WIDTH-1]);
        end
    endgenerate

endmodule

// File: rtl/seq_hold_fsm.sv
module seq_hold_fsm
    import seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cancel,
    input  logic irq,
    input  logic at_slot,
    output logic stall,
    output logic hold_first,
    output logic hold_second
);

    hold_phase_e phase_q;
    hold_phase_e phase_d;

    always_comb begin
        phase_d = PH_RUN;
        unique case (phase_q)
            PH_RUN: begin
                if (irq && at_slot && !cancel) begin
                    phase_d = PH_HOLD1;
                end
            end
            PH_HOLD1: begin
                if (!cancel) begin
                    phase_d = PH_HOLD2;
                end
            end
            PH_HOLD2: begin
                phase_d = PH_RUN;
            end
            default: begin
                phase_d = PH_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_RUN;
        end else begin
            phase_q <= phase_d;
        end
    end

    always_comb begin
        hold_first  = 1'b0;
        hold_second = 1'b0;
        stall       = 1'b0;
        unique case (phase_q)
            PH_RUN: begin
                stall = (phase_d == PH_HOLD1);
            end
            PH_HOLD1: begin
                hold_first = 1'b1;
                stall      = !cancel;
            end
            PH_HOLD2: begin
                hold_second = 1'b1;
            end
            default: begin
                stall = 1'b0;
            end
        endcase
    end

    // R7
    hold_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_first && !cancel) |=> hold_second);

    // R8
    no_retrigger_chk: assert property (@(posedge clk) disable iff (rst)
        hold_second |=> !hold_first);

    // R11
    cancel_clears_chk: assert property (@(posedge clk) disable iff (rst)
        cancel |=> (!hold_first && !hold_second));

endmodule

// File: rtl/mcycle_sequencer.sv
module mcycle_sequencer #(
    parameter int NUM_M = 6,
    parameter int NUM_T = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_first_i,
    input  logic             next_cycle_i,
    input  logic             irq_service_i,
    output logic [NUM_M-1:0] mcyc_o,
    output logic [NUM_T-1:0] tclk_o,
    output logic             hold_first_o,
    output logic             hold_second_o,
    output logic             ir_load_o
);

    localparam int HOLD_T_IDX = 1;
    localparam int LOAD_T_IDX = HOLD_T_IDX + 1;
    localparam int LAST_T_IDX = NUM_T - 1;

    logic m_clear;
    logic m_adv;
    logic t_clear;
    logic t_adv;
    logic stall;
    logic at_slot;
    logic ctrl_any;

    assign ctrl_any = set_first_i || next_cycle_i;
    assign at_slot  = mcyc_o[0] && tclk_o[HOLD_T_IDX];

    seq_hold_fsm u_hold (
        .clk        (clk),
        .rst        (rst),
        .cancel     (ctrl_any),
        .irq        (irq_service_i),
        .at_slot    (at_slot),
        .stall      (stall),
        .hold_first (hold_first_o),
        .hold_second(hold_second_o)
    );

    assign t_clear = rst || ctrl_any;
    assign t_adv   = !stall;
    assign m_clear = rst || set_first_i;
    assign m_adv   = next_cycle_i || (tclk_o[LAST_T_IDX] && t_adv);

    seq_onehot_counter #(
        .WIDTH   (NUM_T),
        .SATURATE(1'b0)
    ) u_tcnt (
        .clk    (clk),
        .rst    (rst),
        .clear  (t_clear),
        .advance(t_adv),
        .state  (tclk_o)
    );

    seq_onehot_counter #(
        .WIDTH   (NUM_M),
        .SATURATE(1'b1)
    ) u_mcnt (
        .clk    (clk),
        .rst    (rst),
        .clear  (m_clear),
        .advance(m_adv),
        .state  (mcyc_o)
    );

    assign ir_load_o = mcyc_o[0] && tclk_o[LOAD_T_IDX] && !hold_first_o && !hold_second_o;

    // R4 R6
    restart_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_first_i |=> (mcyc_o[0] && tclk_o[0]));

    // R5
    next_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (next_cycle_i && !set_first_i) |=> tclk_o[0]);

    // R7
    frozen_first_chk: assert property (@(posedge clk) disable iff (rst)
        hold_first_o |-> (tclk_o == $past(tclk_o)));

    // R7
    frozen_second_chk: assert property (@(posedge clk) disable iff (rst)
        hold_second_o |-> (tclk_o == $past(tclk_o)));

    // R9
    load_after_t2_chk: assert property (@(posedge clk) disable iff (rst)
        ir_load_o |-> $past(tclk_o[HOLD_T_IDX]));

endmodule

// File: tb/mcycle_sequencer_test.sv
module mcycle_sequencer_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       set_first_i;
    logic       next_cycle_i;
    logic       irq_service_i;
    logic [5:0] mcyc_o;
    logic [5:0] tclk_o;
    logic       hold_first_o;
    logic       hold_second_o;
    logic       ir_load_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mcycle_sequencer uut (
        .clk          (clk),
        .rst          (rst),
        .set_first_i  (set_first_i),
        .next_cycle_i (next_cycle_i),
        .irq_service_i(irq_service_i),
        .mcyc_o       (mcyc_o),
        .tclk_o       (tclk_o),
        .hold_first_o (hold_first_o),
        .hold_second_o(hold_second_o),
        .ir_load_o    (ir_load_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_state(input int m, input int t, input bit h1, input bit h2,
                                input bit ir, input string req);
        logic [5:0] em;
        logic [5:0] et;
        em = 6'b1 << (m - 1);
        et = 6'b1 << (t - 1);
        checks++;
        if (mcyc_o !== em || tclk_o !== et || hold_first_o !== h1 ||
            hold_second_o !== h2 || ir_load_o !== ir) begin
            fails++;
            $display("FAIL %s: actual m=%b t=%b h1=%b h2=%b ir=%b expected m=%b t=%b h1=%b h2=%b ir=%b",
                     req, mcyc_o, tclk_o, hold_first_o, hold_second_o, ir_load_o,
                     em, et, h1, h2, ir);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        rst = 1'b0;
    endtask

    task automatic test_reset();
        set_first_i = 1'b0; next_cycle_i = 1'b0; irq_service_i = 1'b0;
        rst = 1'b1;
        tick();
        tick();
        expect_state(1, 1, 0, 0, 0, "R1 reset state");
        rst = 1'b0;
    endtask

    task automatic test_free_run();
        do_reset();
        for (int m = 1; m <= 6; m++) begin
            for (int t = 1; t <= 6; t++) begin
                expect_state(m, t, 0, 0, (m == 1 && t == 3), "R2 R3 R9 free run");
                if (!(m == 6 && t == 6)) tick();
            end
        end
        tick();
        expect_state(6, 1, 0, 0, 0, "R3 saturate at M6");
    endtask

    task automatic test_controls();
        do_reset();
        tick(); tick(); tick();
        expect_state(1, 4, 0, 0, 0, "R2 reach T4");
        next_cycle_i = 1'b1;
        tick();
        next_cycle_i = 1'b0;
        expect_state(2, 1, 0, 0, 0, "R5 next cycle");
        tick(); tick();
        set_first_i = 1'b1;
        tick();
        set_first_i = 1'b0;
        expect_state(1, 1, 0, 0, 0, "R4 restart");
        tick(); tick();
        set_first_i = 1'b1; next_cycle_i = 1'b1;
        tick();
        set_first_i = 1'b0; next_cycle_i = 1'b0;
        expect_state(1, 1, 0, 0, 0, "R6 priority");
        for (int i = 0; i < 5; i++) begin
            next_cycle_i = 1'b1;
            tick();
        end
        expect_state(6, 1, 0, 0, 0, "R5 reach M6");
        tick();
        tick();
        next_cycle_i = 1'b1;
        tick();
        next_cycle_i = 1'b0;
        expect_state(6, 1, 0, 0, 0, "R5 next cycle saturates");
    endtask

    task automatic test_irq_hold();
        do_reset();
        irq_service_i = 1'b1;
        expect_state(1, 1, 0, 0, 0, "R8 no hold at T1");
        tick();
        expect_state(1, 2, 0, 0, 0, "R7 enter T2");
        tick();
        expect_state(1, 2, 1, 0, 0, "R7 first hold");
        tick();
        expect_state(1, 2, 0, 1, 0, "R7 second hold");
        tick();
        expect_state(1, 3, 0, 0, 1, "R7 R9 resume at T3");
        tick();
        expect_state(1, 4, 0, 0, 0, "R8 single insertion");
        next_cycle_i = 1'b1;
        tick();
        next_cycle_i = 1'b0;
        tick();
        expect_state(2, 2, 0, 0, 0, "R8 M2/T2");
        tick();
        expect_state(2, 3, 0, 0, 0, "R8 no hold outside M1");
        irq_service_i = 1'b0;
        do_reset();
        tick();
        tick();
        expect_state(1, 3, 0, 0, 1, "R8 no hold with flag low");
    endtask

    task automatic test_cancel();
        do_reset();
        irq_service_i = 1'b1;
        tick(); tick();
        expect_state(1, 2, 1, 0, 0, "R7 hold before cancel");
        set_first_i = 1'b1;
        tick();
        set_first_i = 1'b0;
        expect_state(1, 1, 0, 0, 0, "R11 restart cancels hold");
        tick(); tick();
        next_cycle_i = 1'b1;
        tick();
        next_cycle_i = 1'b0;
        expect_state(2, 1, 0, 0, 0, "R11 next cycle cancels hold");
        set_first_i = 1'b1;
        tick();
        set_first_i = 1'b0;
        tick(); tick();
        expect_state(1, 2, 1, 0, 0, "R7 hold before reset");
        rst = 1'b1;
        tick();
        rst = 1'b0;
        expect_state(1, 1, 0, 0, 0, "R1 reset clears hold");
        irq_service_i = 1'b0;
        tick();
        tick();
        expect_state(1, 3, 0, 0, 1, "R1 clean after reset");
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        #1;
        test_reset();
        test_free_run();
        test_controls();
        test_irq_hold();
        test_cancel();
        report();
    end

endmodule